// File: doc/BRIEF.md
# Limit-Wrapping Interval Timer Array

This block is a bank of interval timers. It has one broadcast channel and a parameterised number of per-processor channels. Every channel holds a 21-bit counter, a 21-bit limit and a sticky event flag. On each cycle in which the shared tick enable is high, every counter advances by one. When the incremented value would equal a nonzero limit, the counter reloads to 1 instead of 0, and the channel's flag is set. A period of N ticks is therefore programmed as a limit of N+1.

The broadcast channel's flag drives one interrupt line per processor, and all of those lines rise together. Each per-processor channel's flag drives only its own processor's line. A flag, and the interrupt it drives, stays high until software reads that channel's limit register.

Software uses a single-cycle register bus with valid, write, word address and data signals. Each channel has three registers:
- a limit register, whose write restarts the count;
- a count register, which is read-only;
- a second limit register, whose write changes the limit without touching the count.

Top module: `tick_timer_array`

## Requirements
- R1: After synchronous reset every count is 0, every flag and interrupt output is low, each per-processor limit field is 0x2710 (register word 0x009C4000), and the broadcast limit field is 0.
- R2: A counter increases by exactly one on each clock cycle in which `tick_en` is high, and holds its value when `tick_en` is low.
- R3: On a tick where count+1 equals a nonzero limit, the counter loads 1 instead of that value and the channel flag sets. A limit of 0 never sets the flag.
- R4: Every register word places the flag at bit 31 and the 21-bit value at bits 30:10, and reads 0 in bits 9:0. A write takes only bits 30:10 of `bus_wdata`.
- R5: Channel index NUM_CPU is the broadcast channel, and its flag drives every bit of `irq_bcast`. Channel i < NUM_CPU drives only `irq_local[i]`.
- R6: A write to register code 0 (limit) loads the limit and clears both the count and the flag of that channel.
- R7: A write to register code 2 (keep-count limit) loads the limit and leaves the count and the flag unchanged.
- R8: A read of code 0 returns the flag and limit, and then clears the flag. Reads of code 1 (count) and code 2 return their words and leave the flag set.
- R9: When a wrap and a flag-clearing read fall in the same cycle, the flag stays set, and the read returns the flag as it stood before that cycle.
- R10: Writes to code 1, to code 3, or to a channel index above NUM_CPU change nothing. Reads of code 3 or of such channels return 0.
- R11: The word address is channel*4+code. `bus_rdata` carries the read word in the cycle after a read request, and is 0 in the cycle after any other cycle.
- R12: When a limit write (code 0) and a wrap fall in the same cycle, the write wins: the count becomes 0 and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances every counter by one when high |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(NUM_CPU+1)+2 | Word address, channel*4+code |
| bus_wdata | input | 32 | Write word; bits 30:10 are used |
| bus_rdata | output | 32 | Read word, one cycle after the request |
| irq_bcast | output | NUM_CPU | Broadcast channel interrupt, one copy per processor |
| irq_local | output | NUM_CPU | Per-processor channel interrupts |

## Verification
Two pairs of functions can fall in the same cycle. A tick that wraps a channel can coincide with a flag-clearing limit read. A tick that wraps a channel can also coincide with a limit write. Directed sequences step a small limit up to one count below the wrap and then issue the read or the write together with the tick. The bench judges the returned word, the interrupt line after the edge, and a follow-up count read. The constrained random phase uses small limits and frequent ticks, so both collisions recur many times, and a bench model written from the requirements checks every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W     = 21;
    localparam int FIELD_LSB = 10;
    localparam int WORD_W    = 32;
    localparam int CODE_W    = 2;

    typedef enum logic [CODE_W-1:0] {
        REG_LIMIT    = 2'd0,
        REG_COUNT    = 2'd1,
        REG_LIMIT_NC = 2'd2,
        REG_RSVD     = 2'd3
    } reg_code_e;

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
    } chan_state_t;

    typedef struct packed {
        logic             load_clr;
        logic             load_keep;
        logic             rd_clr;
        logic [CNT_W-1:0] value;
    } chan_cmd_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic flag,
                                                    input logic [CNT_W-1:0] val);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1] = flag;
        w[FIELD_LSB +: CNT_W] = val;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] field_of(input logic [WORD_W-1:0] w);
        return w[FIELD_LSB +: CNT_W];
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CH_W   = 3
) (
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [CH_W+CODE_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output chan_cmd_t              cmd [NUM_CH],
    output logic                   rd_req,
    output logic [CH_W-1:0]        rd_chan,
    output reg_code_e              rd_code
);
    logic [CH_W-1:0] sel_chan;
    reg_code_e       sel_code;

    assign sel_chan = bus_addr[CH_W+CODE_W-1:CODE_W];
    assign sel_code = reg_code_e'(bus_addr[CODE_W-1:0]);
    assign rd_req   = bus_valid && !bus_write;
    assign rd_chan  = sel_chan;
    assign rd_code  = sel_code;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmd
        logic hit;
        assign hit = bus_valid && (sel_chan == CH_W'(i));
        always_comb begin
            cmd[i].load_clr  = hit && bus_write  && (sel_code == REG_LIMIT);
            cmd[i].load_keep = hit && bus_write  && (sel_code == REG_LIMIT_NC);
            cmd[i].rd_clr    = hit && !bus_write && (sel_code == REG_LIMIT);
            cmd[i].value     = field_of(bus_wdata);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter logic [CNT_W-1:0] LIMIT_RST = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  chan_cmd_t   cmd,
    output chan_state_t st
);
    logic [CNT_W-1:0] cnt_inc;
    logic             wrap;

    assign cnt_inc = st.count + 1'b1;
    assign wrap    = tick && (st.limit != '0) && (cnt_inc == st.limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.flag  <= 1'b0;
            st.count <= '0;
            st.limit <= LIMIT_RST;
        end else if (cmd.load_clr) begin
            // restart wins over any wrap in the same cycle
            st.limit <= cmd.value;
            st.count <= '0;
            st.flag  <= 1'b0;
        end else begin
            if (cmd.load_keep) begin
                st.limit <= cmd.value;
            end
            if (wrap) begin
                st.count <= CNT_W'(1);
            end else if (tick) begin
                st.count <= cnt_inc;
            end
            // setting beats clearing so no event is lost
            if (wrap) begin
                st.flag <= 1'b1;
            end else if (cmd.rd_clr) begin
                st.flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_readmux.sv
module tmr_readmux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_state_t       st [NUM_CH],
    input  logic              rd_req,
    input  logic [CH_W-1:0]   rd_chan,
    input  reg_code_e         rd_code,
    output logic [WORD_W-1:0] rdata
);
    chan_state_t       pick;
    logic              mapped;
    logic [WORD_W-1:0] word;

    always_comb begin
        pick   = '0;
        mapped = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_chan == CH_W'(i)) begin
                pick   = st[i];
                mapped = 1'b1;
            end
        end
    end

    always_comb begin
        word = '0;
        if (mapped) begin
            unique case (rd_code)
                REG_LIMIT, REG_LIMIT_NC: word = pack_word(pick.flag, pick.limit);
                REG_COUNT:               word = pack_word(pick.flag, pick.count);
                REG_RSVD:                word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= word;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/tick_timer_array.sv
module tick_timer_array
    import tmr_pkg::*;
#(
    parameter int               NUM_CPU          = 4,
    parameter logic [CNT_W-1:0] CPU_LIMIT_RST    = 21'h02710,
    parameter logic [CNT_W-1:0] MASTER_LIMIT_RST = 21'h00000,
    localparam int              NUM_CH           = NUM_CPU + 1,
    localparam int              CH_W             = $clog2(NUM_CH),
    localparam int              ADDR_W           = CH_W + CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [NUM_CPU-1:0] irq_bcast,
    output logic [NUM_CPU-1:0] irq_local
);
    chan_cmd_t       cmd [NUM_CH];
    chan_state_t     st  [NUM_CH];
    logic            rd_req;
    logic [CH_W-1:0] rd_chan;
    reg_code_e       rd_code;

    tmr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .rd_req    (rd_req),
        .rd_chan   (rd_chan),
        .rd_code   (rd_code)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        localparam logic [CNT_W-1:0] RST_LIM =
            (i == NUM_CPU) ? MASTER_LIMIT_RST : CPU_LIMIT_RST;
        tmr_channel #(.LIMIT_RST(RST_LIM)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_en),
            .cmd  (cmd[i]),
            .st   (st[i])
        );
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        assign irq_local[c] = st[c].flag;
        assign irq_bcast[c] = st[NUM_CPU].flag;
    end

    tmr_readmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rmux (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .rd_req  (rd_req),
        .rd_chan (rd_chan),
        .rd_code (rd_code),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/tick_timer_array_chk.sv
module tick_timer_array_chk #(
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_en,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CPU-1:0] irq_bcast,
    input logic [NUM_CPU-1:0] irq_local
);
    // an interrupt can only rise on a ticking edge
    assert_rise_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
        ((|(irq_local & ~$past(irq_local))) || (|(irq_bcast & ~$past(irq_bcast))))
        |-> $past(tick_en));

    // an interrupt can only fall after a bus access
    assert_fall_needs_bus_R8: assert property (@(posedge clk) disable iff (rst)
        ((|(~irq_local & $past(irq_local))) || (|(~irq_bcast & $past(irq_bcast))))
        |-> $past(bus_valid));

    // no tick and no access: interrupt lines hold
    assert_quiet_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !bus_valid) |=> ($stable(irq_local) && $stable(irq_bcast)));

    assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[9:0] == 10'd0);

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid && !bus_write) |-> (bus_rdata == 32'd0));
endmodule

bind tick_timer_array tick_timer_array_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_rdata (bus_rdata),
    .irq_bcast (irq_bcast),
    .irq_local (irq_local)
);

// File: tb/tick_timer_array_bench.sv
module tick_timer_array_bench;
    localparam int NCPU = 4;
    localparam int NCH  = NCPU + 1;
    localparam int AW   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCPU-1:0] irq_bcast, irq_local;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [20:0] m_cnt [NCH];
    logic [20:0] m_lim [NCH];
    logic        m_flag[NCH];
    logic [31:0] exp_rd;

    always #2 clk = ~clk;

    tick_timer_array u_tick_timer_array (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_bcast(irq_bcast), .irq_local(irq_local)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic f, input logic [20:0] v);
        return {f, v, 10'd0};
    endfunction

    // R11: word address = channel*4 + code
    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int ch = int'(a[AW-1:2]);
        if (ch >= NCH) return 32'd0;
        case (a[1:0])
            2'd0, 2'd2: return word_of(m_flag[ch], m_lim[ch]);
            2'd1:       return word_of(m_flag[ch], m_cnt[ch]);
            default:    return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i]  = '0;
            m_flag[i] = 1'b0;
            m_lim[i]  = (i == NCPU) ? 21'd0 : 21'h02710;
        end
    endtask

    task automatic model_step(input logic t, input logic v, input logic w,
                              input logic [AW-1:0] a, input logic [31:0] d);
        for (int i = 0; i < NCH; i++) begin
            logic hit, ldc, ldk, rdc, wr;
            hit = v && (int'(a[AW-1:2]) == i);
            ldc = hit && w && (a[1:0] == 2'd0);
            ldk = hit && w && (a[1:0] == 2'd2);
            rdc = hit && !w && (a[1:0] == 2'd0);
            wr  = t && (m_lim[i] != 0) && (21'(m_cnt[i] + 1) == m_lim[i]);
            if (ldc) begin
                m_lim[i] = d[30:10]; m_cnt[i] = '0; m_flag[i] = 1'b0;
            end else begin
                if (wr) m_cnt[i] = 21'd1;
                else if (t) m_cnt[i] = m_cnt[i] + 1;
                if (wr) m_flag[i] = 1'b1;
                else if (rdc) m_flag[i] = 1'b0;
                if (ldk) m_lim[i] = d[30:10];
            end
        end
    endtask

    task automatic step(input logic t, input logic v, input logic w,
                        input logic [AW-1:0] a, input logic [31:0] d);
        logic [NCPU-1:0] exp_loc;
        tick_en = t; bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        exp_rd = (v && !w) ? model_read(a) : 32'd0;
        model_step(t, v, w, a, d);
        @(negedge clk);
        for (int i = 0; i < NCPU; i++) exp_loc[i] = m_flag[i];
        chk("R11 rdata vs model", bus_rdata, exp_rd);
        chk("R5 irq_local vs model", 32'(irq_local), 32'(exp_loc));
        chk("R5 irq_bcast vs model", 32'(irq_bcast), m_flag[NCPU] ? 32'hF : 32'h0);
        tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        step(1'b0, 1'b1, 1'b0, a, 32'd0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, '0, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 irq_local after reset", 32'(irq_local), 32'd0);
        chk("R1 irq_bcast after reset", 32'(irq_bcast), 32'd0);
        rd(5'd0);  chk("R1 cpu limit reset word", bus_rdata, 32'h009C4000);
        rd(5'd16); chk("R1 master limit reset", bus_rdata, 32'h0);
        rd(5'd1);  chk("R1 count reset", bus_rdata, 32'h0);

        // R6 / R2 / R3 on channel 1, limit 4
        step(1'b0, 1'b1, 1'b1, 5'd4, 32'h0000_1000);
        tk(3);
        rd(5'd5);  chk("R2 count after 3 ticks", bus_rdata, 32'h0000_0C00);
        step(1'b0, 1'b0, 1'b0, '0, 32'd0);
        rd(5'd5);  chk("R2 count holds without tick", bus_rdata, 32'h0000_0C00);
        tk(1);
        chk("R5 local line of channel 1 only", 32'(irq_local), 32'h2);
        chk("R5 bcast untouched", 32'(irq_bcast), 32'h0);
        rd(5'd5);  chk("R3 R4 count reloads to 1 with flag", bus_rdata, 32'h8000_0400);
        rd(5'd6);  chk("R8 keep-count limit read", bus_rdata, 32'h8000_1000);
        chk("R8 count and nc reads keep flag", 32'(irq_local[1]), 32'd1);
        rd(5'd4);  chk("R8 limit read returns flag", bus_rdata, 32'h8000_1000);
        chk("R8 limit read clears irq", 32'(irq_local[1]), 32'd0);
        rd(5'd4);  chk("R8 flag cleared", bus_rdata, 32'h0000_1000);

        // R7: keep-count limit write
        step(1'b0, 1'b1, 1'b1, 5'd6, 32'h0000_2800);
        rd(5'd5);  chk("R7 count kept", bus_rdata, 32'h0000_0400);
        rd(5'd4);  chk("R7 limit loaded", bus_rdata, 32'h0000_2800);

        // R10: ignored writes and empty reads
        step(1'b0, 1'b1, 1'b1, 5'd5, 32'h7FFF_FC00);
        rd(5'd5);  chk("R10 count write ignored", bus_rdata, 32'h0000_0400);
        step(1'b0, 1'b1, 1'b1, 5'd3, 32'h7FFF_FC00);
        step(1'b0, 1'b1, 1'b1, 5'd24, 32'h7FFF_FC00);
        rd(5'd3);  chk("R10 reserved code reads 0", bus_rdata, 32'h0);
        rd(5'd24); chk("R10 unmapped channel reads 0", bus_rdata, 32'h0);
        rd(5'd0);  chk("R10 channel 0 limit unchanged", bus_rdata, 32'h009C4000);

        // R4 / R6 on channel 2: junk bits dropped, count cleared
        step(1'b0, 1'b1, 1'b1, 5'd8, 32'h8000_0FFF);
        rd(5'd8);  chk("R4 only bits 30:10 written", bus_rdata, 32'h0000_0C00);
        rd(5'd9);  chk("R6 limit write clears count", bus_rdata, 32'h0);

        // R9: wrap and clearing read in the same cycle
        tk(3);
        chk("R3 channel 2 wraps at limit 3", 32'(irq_local[2]), 32'd1);
        tk(1);
        step(1'b1, 1'b1, 1'b0, 5'd8, 32'd0);
        chk("R9 read word in colliding cycle", bus_rdata, 32'h8000_0C00);
        chk("R9 flag survives colliding read", 32'(irq_local[2]), 32'd1);
        rd(5'd8);
        chk("R8 later read clears", 32'(irq_local[2]), 32'd0);

        // R12: limit write and wrap in the same cycle on channel 3
        step(1'b0, 1'b1, 1'b1, 5'd12, 32'h0000_0800);
        tk(1);
        step(1'b1, 1'b1, 1'b1, 5'd12, 32'h0000_0800);
        chk("R12 write beats wrap, no flag", 32'(irq_local[3]), 32'd0);
        rd(5'd13); chk("R12 count restarted", bus_rdata, 32'h0);

        // R5: broadcast channel
        step(1'b0, 1'b1, 1'b1, 5'd16, 32'h0000_0800);
        tk(2);
        chk("R5 bcast to every cpu", 32'(irq_bcast), 32'hF);
        rd(5'd16); chk("R8 bcast limit read", bus_rdata, 32'h8000_0800);
        chk("R5 bcast cleared", 32'(irq_bcast), 32'h0);

        // R3 limit 0 never flags
        step(1'b0, 1'b1, 1'b1, 5'd16, 32'h0);
        tk(4);
        chk("R3 zero limit sets no flag", 32'(irq_bcast), 32'h0);

        // constrained random traffic, small limits, frequent ticks
        for (int k = 0; k < 3000; k++) begin
            logic        t, v, w;
            logic [AW-1:0] a;
            logic [31:0] d;
            t = ($urandom_range(3) != 0);
            v = ($urandom_range(9) < 4);
            w = $urandom_range(1);
            a = AW'($urandom_range(23));
            d = {$urandom_range(1) == 1, 21'($urandom_range(6)), 10'($urandom)};
            step(t, v, w, a, d);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule